// File: doc/BRIEF.md
# Handshaked Parallel Bus Slave

This block is the slave end of an 8-bit, bidirectional, strobe-and-acknowledge parallel bus. The master sets a 2-bit cycle identifier and a read/write line, then raises an active-high enable. The slave finishes its part of the cycle by pulling a shared open-drain acknowledge low. It lets go of the acknowledge only after the master has dropped enable. The block resynchronises the master's control lines and decodes eight cycle kinds. For each accepted cycle it emits a one-clock request strobe toward the buffers and registers that sit outside it. On reads it drives the selected byte onto the data bus before it acknowledges.

A chip-select cycle carries a 4-bit target address and a listen/unlisten flag. Only a slave whose static address matches answers it. A slave answers every other kind of cycle only while it is listening. If an unlisten reaches a slave that is already unlistened, the slave completes the handshake and then issues a one-cycle full-reset pulse, which returns the surrounding logic to its power-up state. The data-bus drive and the acknowledge pull-down are separate output-enable outputs, so the wired-AND bus can be modelled outside the block.

Top module: `pbus_slave`

## Requirements
- R1: After reset the slave is unlistened (`listening`=0), and `ack_pull`, `bus_doe`, `full_reset` and every request strobe are 0.
- R2: A chip-select cycle ({cid,rd}=3'b100) whose data bits 3:0 equal `slave_addr` and whose bit 7 is 1 is acknowledged and sets `listening` to 1. Data bits 6:4 have no effect.
- R3: A chip-select cycle whose data bits 3:0 differ from `slave_addr` gets no acknowledge and leaves `listening` unchanged.
- R4: While unlistened, any cycle other than chip select gets no acknowledge and raises no request strobe.
- R5: While listening, write cycles ({cid,rd}=000 push transmit, 010 load indirect address, 110 write register) raise their own strobe (`tx_push`, `iaddr_load`, `reg_write`) with `wr_data` equal to the data bus sampled while enable was high. The acknowledge follows.
- R6: While listening, read cycles drive `bus_dout` with `rx_rdata` for 001, `tx_free` for 011, `rx_count` for 101 and `reg_rdata` for 111. `bus_doe` rises at least one clock before `ack_pull`. Code 001 pulses `rx_pop`, code 111 pulses `reg_read`, and the two count reads pulse no strobe.
- R7: `ack_pull` stays high until enable is seen low. It then falls in the same clock as `bus_doe`.
- R8: A matching chip select with bit 7 = 0, sent while listening, is acknowledged and clears `listening` without a full reset.
- R9: A matching chip select with bit 7 = 0, sent while already unlistened, is acknowledged. In the clock in which the acknowledge is released, `full_reset` pulses once.
- R10: Each accepted cycle raises exactly one strobe pulse, however long enable is held, and no two strobes are ever high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slave_addr | input | 4 | Static address matched by chip select |
| bus_en | input | 1 | Master enable strobe, active high, asynchronous |
| bus_cid | input | 2 | Master cycle identifier, asynchronous |
| bus_rd | input | 1 | 1 for a read cycle, 0 for a write, asynchronous |
| bus_din | input | 8 | Resolved data bus value |
| bus_dout | output | 8 | Byte driven on reads |
| bus_doe | output | 1 | Data bus drive enable |
| ack_pull | output | 1 | 1 pulls the open-drain acknowledge low |
| listening | output | 1 | Slave currently answers non-select cycles |
| rx_rdata | input | 8 | Head byte of the receive buffer |
| tx_free | input | 8 | Free bytes in the transmit buffer |
| rx_count | input | 8 | Bytes held in the receive buffer |
| reg_rdata | input | 8 | Register at the indirect address |
| tx_push | output | 1 | Push `wr_data` into the transmit buffer |
| rx_pop | output | 1 | Pop the receive buffer |
| iaddr_load | output | 1 | Load indirect address from `wr_data` |
| reg_write | output | 1 | Write `wr_data` to the indirect register |
| reg_read | output | 1 | Indirect register was read |
| wr_data | output | 8 | Byte captured on write cycles |
| full_reset | output | 1 | One-clock power-up reset request |

## Verification
The slave is driven through complete handshakes of every cycle code. Each code gets its own data and source values, so a wrong decode shows up as a wrong strobe or byte. Chip selects are sent with matching and mismatching addresses and with the ignored bits 6:4 set, which separates address comparison from field masking. Listen, unlisten and double unlisten are sent in sequence, which separates a plain unlisten from the reset case. One cycle holds enable for twenty extra clocks, which separates single-pulse strobes from level-driven ones.

// File: rtl/pbus_pkg.sv
// Shared types for the parallel bus slave.
// Cycle codes are {cid, rd} as presented by the master.
package pbus_pkg;
    typedef enum logic [2:0] {
        CYC_TX_PUSH = 3'b000,
        CYC_RX_POP  = 3'b001,
        CYC_IADDR   = 3'b010,
        CYC_TX_FREE = 3'b011,
        CYC_SELECT  = 3'b100,
        CYC_RX_CNT  = 3'b101,
        CYC_REG_WR  = 3'b110,
        CYC_REG_RD  = 3'b111
    } cyc_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HOLD,
        ST_SKIP
    } hs_state_e;
endpackage

// File: rtl/pbus_sync.sv
// Multi-stage synchroniser for a vector of asynchronous control lines.
// Assumes each bit is independently meaningful or that the lines are held
// stable around the enable edge by the bus protocol.
module pbus_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    // Shift the inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pbus_decode.sv
// Maps the synchronised cycle identifier and direction to a cycle kind.
// Purely combinational; assumes inputs come from pbus_sync.
module pbus_decode
    import pbus_pkg::*;
(
    input  logic [1:0] cid_s,
    input  logic       rd_s,
    output cyc_kind_e  kind,
    output logic       is_select,
    output logic       is_read
);
    // Form the 3-bit cycle code and its flags.
    always_comb begin
        kind      = cyc_kind_e'({cid_s, rd_s});
        is_select = (kind == CYC_SELECT);
        is_read   = rd_s;
    end
endmodule

// File: rtl/pbus_fsm.sv
// Handshake sequencer: accepts a cycle when enable is seen high, handles
// listen state, raises request strobes, drives read data one clock ahead of
// the acknowledge and holds the acknowledge until enable is seen low.
// Assumes data bus is stable while enable is high (bus protocol).
module pbus_fsm
    import pbus_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_s,
    input  cyc_kind_e     kind,
    input  logic          is_select,
    input  logic          is_read,
    input  logic [DW-1:0] din,
    input  logic [AW-1:0] my_addr,
    input  logic [DW-1:0] rx_rdata,
    input  logic [DW-1:0] tx_free,
    input  logic [DW-1:0] rx_count,
    input  logic [DW-1:0] reg_rdata,
    output logic [DW-1:0] dout,
    output logic          doe,
    output logic          ack,
    output logic          listen,
    output logic          tx_push,
    output logic          rx_pop,
    output logic          iaddr_load,
    output logic          reg_write,
    output logic          reg_read,
    output logic [DW-1:0] wr_data,
    output logic          full_reset
);
    localparam int LISTEN_BIT = DW - 1;

    hs_state_e     state;
    logic          reset_pend;
    logic          addr_hit;
    logic [DW-1:0] rd_sel;

    // Compare the chip-select address field with our own address.
    always_comb addr_hit = (din[AW-1:0] == my_addr);

    // Choose the byte that a read cycle returns.
    always_comb begin
        unique case (kind)
            CYC_RX_POP:  rd_sel = rx_rdata;
            CYC_TX_FREE: rd_sel = tx_free;
            CYC_RX_CNT:  rd_sel = rx_count;
            CYC_REG_RD:  rd_sel = reg_rdata;
            default:     rd_sel = '0;
        endcase
    end

    // Handshake state, listen flag, strobes and data registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            listen     <= 1'b0;
            reset_pend <= 1'b0;
            dout       <= '0;
            doe        <= 1'b0;
            wr_data    <= '0;
            tx_push    <= 1'b0;
            rx_pop     <= 1'b0;
            iaddr_load <= 1'b0;
            reg_write  <= 1'b0;
            reg_read   <= 1'b0;
            full_reset <= 1'b0;
        end else begin
            tx_push    <= 1'b0;
            rx_pop     <= 1'b0;
            iaddr_load <= 1'b0;
            reg_write  <= 1'b0;
            reg_read   <= 1'b0;
            full_reset <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (en_s) begin
                        if (is_select) begin
                            if (addr_hit) begin
                                state <= ST_HOLD;
                                if (din[LISTEN_BIT])  listen <= 1'b1;
                                else if (listen)      listen <= 1'b0;
                                else                  reset_pend <= 1'b1;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end else if (!listen) begin
                            state <= ST_SKIP;
                        end else if (is_read) begin
                            dout     <= rd_sel;
                            doe      <= 1'b1;
                            rx_pop   <= (kind == CYC_RX_POP);
                            reg_read <= (kind == CYC_REG_RD);
                            state    <= ST_LEAD;
                        end else begin
                            wr_data    <= din;
                            tx_push    <= (kind == CYC_TX_PUSH);
                            iaddr_load <= (kind == CYC_IADDR);
                            reg_write  <= (kind == CYC_REG_WR);
                            state      <= ST_HOLD;
                        end
                    end
                end
                ST_LEAD: state <= ST_HOLD;
                ST_HOLD: begin
                    if (!en_s) begin
                        state <= ST_IDLE;
                        doe   <= 1'b0;
                        if (reset_pend) begin
                            full_reset <= 1'b1;
                            reset_pend <= 1'b0;
                            dout       <= '0;
                            wr_data    <= '0;
                        end
                    end
                end
                default: begin
                    if (!en_s) state <= ST_IDLE;
                end
            endcase
        end
    end

    assign ack = (state == ST_HOLD);
endmodule

// File: rtl/pbus_slave.sv
// Top of the parallel bus slave. Synchronises the master's control lines,
// decodes the cycle and runs the handshake sequencer. The data bus itself is
// not synchronised: the protocol keeps it stable while enable is high.
module pbus_slave #(
    parameter int DW          = 8,
    parameter int AW          = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] slave_addr,
    input  logic          bus_en,
    input  logic [1:0]    bus_cid,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_din,
    output logic [DW-1:0] bus_dout,
    output logic          bus_doe,
    output logic          ack_pull,
    output logic          listening,
    input  logic [DW-1:0] rx_rdata,
    input  logic [DW-1:0] tx_free,
    input  logic [DW-1:0] rx_count,
    input  logic [DW-1:0] reg_rdata,
    output logic          tx_push,
    output logic          rx_pop,
    output logic          iaddr_load,
    output logic          reg_write,
    output logic          reg_read,
    output logic [DW-1:0] wr_data,
    output logic          full_reset
);
    import pbus_pkg::*;

    localparam int CTRL_W = 4;

    logic [CTRL_W-1:0] ctrl_s;
    cyc_kind_e         kind;
    logic              is_select;
    logic              is_read;

    pbus_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({bus_en, bus_cid, bus_rd}),
        .q     (ctrl_s)
    );

    pbus_decode u_dec (
        .cid_s     (ctrl_s[2:1]),
        .rd_s      (ctrl_s[0]),
        .kind      (kind),
        .is_select (is_select),
        .is_read   (is_read)
    );

    pbus_fsm #(.DW(DW), .AW(AW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_s       (ctrl_s[3]),
        .kind       (kind),
        .is_select  (is_select),
        .is_read    (is_read),
        .din        (bus_din),
        .my_addr    (slave_addr),
        .rx_rdata   (rx_rdata),
        .tx_free    (tx_free),
        .rx_count   (rx_count),
        .reg_rdata  (reg_rdata),
        .dout       (bus_dout),
        .doe        (bus_doe),
        .ack        (ack_pull),
        .listen     (listening),
        .tx_push    (tx_push),
        .rx_pop     (rx_pop),
        .iaddr_load (iaddr_load),
        .reg_write  (reg_write),
        .reg_read   (reg_read),
        .wr_data    (wr_data),
        .full_reset (full_reset)
    );
endmodule

// File: rtl/pbus_slave_chk.sv
// Protocol checker for pbus_slave, attached by bind below.
// Assumes rst_n is low from time zero.
module pbus_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic ack_pull,
    input logic bus_doe,
    input logic listening,
    input logic tx_push,
    input logic rx_pop,
    input logic iaddr_load,
    input logic reg_write,
    input logic reg_read,
    input logic full_reset
);
    logic [4:0] strobes;
    assign strobes = {tx_push, rx_pop, iaddr_load, reg_write, reg_read};

    // R6: read data is on the bus before the acknowledge appears
    a_r6_drive_leads_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_doe) |-> !ack_pull);

    // R7: after its lead cycle, data drive only persists inside the handshake
    a_r7_drive_inside_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_doe && $past(bus_doe)) |-> ack_pull);

    // R7: data drive ends no later than the acknowledge release
    a_r7_release_together: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_pull) |-> !bus_doe);

    // R10: never two request strobes at once
    a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strobes));

    // R10: a strobe is a single-clock pulse
    a_r10_pulse_only: assert property (@(posedge clk) disable iff (!rst_n)
        (|strobes) |=> !(|strobes));

    // R4: strobes only while listening
    a_r4_strobe_needs_listen: assert property (@(posedge clk) disable iff (!rst_n)
        (|strobes) |-> listening);

    // R9: full reset follows the acknowledge release, unlistened
    a_r9_reset_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        full_reset |-> (!ack_pull && $past(ack_pull) && !listening));
endmodule

bind pbus_slave pbus_slave_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ack_pull   (ack_pull),
    .bus_doe    (bus_doe),
    .listening  (listening),
    .tx_push    (tx_push),
    .rx_pop     (rx_pop),
    .iaddr_load (iaddr_load),
    .reg_write  (reg_write),
    .reg_read   (reg_read),
    .full_reset (full_reset)
);

// File: tb/pbus_slave_test.sv
// Directed bench for pbus_slave: one task per scenario.
module pbus_slave_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] slave_addr = 4'h5;
    logic       bus_en = 1'b0;
    logic [1:0] bus_cid = 2'b00;
    logic       bus_rd = 1'b0;
    logic [7:0] mdata = 8'h00;
    logic [7:0] bus_din;
    logic [7:0] bus_dout;
    logic       bus_doe, ack_pull, listening;
    logic [7:0] rx_rdata = 8'h3C, tx_free = 8'h11, rx_count = 8'h22, reg_rdata = 8'h77;
    logic       tx_push, rx_pop, iaddr_load, reg_write, reg_read, full_reset;
    logic [7:0] wr_data;
    wire        ack_n = ack_pull ? 1'b0 : 1'b1;

    int n_checks = 0, n_errors = 0;
    int n_tx = 0, n_rx = 0, n_ia = 0, n_rw = 0, n_rr = 0, n_rst = 0;
    logic [7:0] last_wr = 8'h00;

    always #4 clk = ~clk;

    assign bus_din = bus_doe ? bus_dout : mdata;

    pbus_slave uut (
        .clk(clk), .rst_n(rst_n), .slave_addr(slave_addr),
        .bus_en(bus_en), .bus_cid(bus_cid), .bus_rd(bus_rd), .bus_din(bus_din),
        .bus_dout(bus_dout), .bus_doe(bus_doe), .ack_pull(ack_pull), .listening(listening),
        .rx_rdata(rx_rdata), .tx_free(tx_free), .rx_count(rx_count), .reg_rdata(reg_rdata),
        .tx_push(tx_push), .rx_pop(rx_pop), .iaddr_load(iaddr_load), .reg_write(reg_write),
        .reg_read(reg_read), .wr_data(wr_data), .full_reset(full_reset)
    );

    // Count strobe pulses seen at the ports.
    always @(posedge clk) begin
        if (rst_n) begin
            if (tx_push)    begin n_tx++; last_wr = wr_data; end
            if (iaddr_load) begin n_ia++; last_wr = wr_data; end
            if (reg_write)  begin n_rw++; last_wr = wr_data; end
            if (rx_pop)     n_rx++;
            if (reg_read)   n_rr++;
            if (full_reset) n_rst++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One complete bus cycle; returns the byte seen at acknowledge and the
    // number of clocks the data bus was driven before acknowledge.
    task automatic bus_cycle(input logic [2:0] code, input logic [7:0] data,
                             input bit exp_ack, input int hold, input string req,
                             output logic [7:0] rdata, output int lead);
        bit seen = 0;
        bit released = 0;
        rdata = 8'h00;
        lead = 0;
        @(negedge clk);
        bus_cid = code[2:1];
        bus_rd  = code[0];
        mdata   = data;
        @(negedge clk);
        bus_en = 1'b1;
        for (int i = 0; i < 12 && !seen; i++) begin
            @(negedge clk);
            if (ack_pull) begin
                seen = 1;
                rdata = bus_dout;
            end else if (bus_doe) begin
                lead++;
            end
        end
        check(seen == exp_ack, req, "acknowledge", seen, exp_ack);
        repeat (hold) @(negedge clk);
        if (seen) check(ack_pull == 1'b1, "R7", "ack held while enable high", ack_pull, 1);
        bus_en = 1'b0;
        if (seen) begin
            for (int i = 0; i < 12 && !released; i++) begin
                @(negedge clk);
                if (!ack_pull) begin
                    released = 1;
                    check(bus_doe == 1'b0, "R7", "drive off at release", bus_doe, 0);
                end
            end
            check(released, "R7", "ack released", released, 1);
        end else begin
            repeat (6) @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(listening == 1'b0, "R1", "listening", listening, 0);
        check(ack_pull == 1'b0 && bus_doe == 1'b0, "R1", "ack/drive", {ack_pull, bus_doe}, 0);
        check({tx_push, rx_pop, iaddr_load, reg_write, reg_read, full_reset} == 6'b0,
              "R1", "strobes", {tx_push, rx_pop, iaddr_load, reg_write, reg_read, full_reset}, 0);
    endtask

    task automatic t_unlistened_ignored();
        logic [7:0] rd; int ld;
        int tx0 = n_tx, rr0 = n_rr;
        bus_cycle(3'b000, 8'h9A, 0, 0, "R4", rd, ld);
        bus_cycle(3'b111, 8'h00, 0, 0, "R4", rd, ld);
        check(n_tx == tx0 && n_rr == rr0, "R4", "strobes while unlistened", n_tx + n_rr, tx0 + rr0);
        check(listening == 1'b0, "R4", "still unlistened", listening, 0);
    endtask

    task automatic t_select_mismatch(input logic [7:0] data, input logic exp_listen);
        logic [7:0] rd; int ld;
        bus_cycle(3'b100, data, 0, 0, "R3", rd, ld);
        check(listening == exp_listen, "R3", "listen unchanged", listening, exp_listen);
    endtask

    task automatic t_select_listen();
        logic [7:0] rd; int ld;
        bus_cycle(3'b100, 8'hF5, 1, 0, "R2", rd, ld);
        check(listening == 1'b1, "R2", "listen set with bits 6:4 high", listening, 1);
    endtask

    task automatic t_writes();
        logic [7:0] rd; int ld;
        int tx0 = n_tx, ia0 = n_ia, rw0 = n_rw;
        bus_cycle(3'b000, 8'hA1, 1, 0, "R5", rd, ld);
        check(n_tx == tx0 + 1 && last_wr == 8'hA1, "R5", "tx push data", last_wr, 8'hA1);
        bus_cycle(3'b010, 8'h4E, 1, 0, "R5", rd, ld);
        check(n_ia == ia0 + 1 && last_wr == 8'h4E, "R5", "iaddr load data", last_wr, 8'h4E);
        bus_cycle(3'b110, 8'hC3, 1, 0, "R5", rd, ld);
        check(n_rw == rw0 + 1 && last_wr == 8'hC3, "R5", "reg write data", last_wr, 8'hC3);
        check(n_tx == tx0 + 1 && n_ia == ia0 + 1, "R5", "no cross strobes", n_tx + n_ia, tx0 + ia0 + 2);
    endtask

    task automatic t_reads();
        logic [7:0] rd; int ld;
        int rx0 = n_rx, rr0 = n_rr;
        bus_cycle(3'b001, 8'h00, 1, 0, "R6", rd, ld);
        check(rd == 8'h3C && ld >= 1, "R6", "rx data / lead", rd, 8'h3C);
        check(n_rx == rx0 + 1, "R6", "rx pop count", n_rx, rx0 + 1);
        bus_cycle(3'b011, 8'h00, 1, 0, "R6", rd, ld);
        check(rd == 8'h11 && ld >= 1, "R6", "tx free", rd, 8'h11);
        bus_cycle(3'b101, 8'h00, 1, 0, "R6", rd, ld);
        check(rd == 8'h22 && ld >= 1, "R6", "rx count", rd, 8'h22);
        check(n_rx == rx0 + 1 && n_rr == rr0, "R6", "count reads pop nothing", n_rx + n_rr, rx0 + rr0 + 1);
        bus_cycle(3'b111, 8'h00, 1, 0, "R6", rd, ld);
        check(rd == 8'h77 && n_rr == rr0 + 1, "R6", "reg read", rd, 8'h77);
    endtask

    task automatic t_long_enable();
        logic [7:0] rd; int ld;
        int tx0 = n_tx;
        bus_cycle(3'b000, 8'h5D, 1, 20, "R10", rd, ld);
        check(n_tx == tx0 + 1, "R10", "single strobe on long enable", n_tx, tx0 + 1);
    endtask

    task automatic t_unlisten();
        logic [7:0] rd; int ld;
        int r0 = n_rst;
        bus_cycle(3'b100, 8'h05, 1, 0, "R8", rd, ld);
        check(listening == 1'b0, "R8", "unlistened", listening, 0);
        check(n_rst == r0, "R8", "no full reset", n_rst, r0);
    endtask

    task automatic t_double_unlisten();
        logic [7:0] rd; int ld;
        int r0 = n_rst, tx0;
        bus_cycle(3'b100, 8'h75, 1, 0, "R9", rd, ld);
        check(n_rst == r0 + 1, "R9", "one full reset pulse", n_rst, r0 + 1);
        check(listening == 1'b0, "R9", "unlistened after reset", listening, 0);
        tx0 = n_tx;
        bus_cycle(3'b000, 8'h12, 0, 0, "R9", rd, ld);
        check(n_tx == tx0, "R9", "ignored after reset", n_tx, tx0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_unlistened_ignored();
        t_select_mismatch(8'h83, 1'b0);
        t_select_listen();
        t_select_mismatch(8'h0A, 1'b1);
        t_writes();
        t_reads();
        t_long_enable();
        t_unlisten();
        t_double_unlisten();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule